// File: doc/BRIEF.md
# Character Line Editing Buffer

This block gathers one text line from a stream of 8-bit character codes. Each code arrives with a valid strobe. Ordinary codes go into an internal byte store at a write position, and the position then moves forward. Three control codes edit the line in place. The first steps the position back by one. The second throws away everything typed so far. The third closes the line.

Once a line is closed, the block gives a one-clock completion pulse and holds the line. While the line is held, further characters are refused. The stored length is on an output at all times. The consumer reads the stored bytes through an address-in, data-out port that answers in the same cycle. An acknowledge input releases the line and starts a new empty one.

Top module: `line_editor`

## Requirements
- R1: After synchronous active-low reset, the length is 0 and the done pulse, held flag and overflow flag are all low.
- R2: An accepted code other than 0x08, 0x01 and 0x0D is written at byte index equal to the current length, and the length then rises by one. `rd_data` shows the byte at `rd_addr` in the same cycle.
- R3: Code 0x08 lowers the length by one and writes nothing. When the length is already 0, it stays 0.
- R4: Code 0x01 sets the length to 0 and clears the overflow flag.
- R5: Code 0x0D is not stored. In the cycle after it is accepted, `line_done` is high for exactly one cycle and `line_held` goes high. The length stays at its value at that moment.
- R6: While `line_held` is high, incoming codes change neither the length nor the stored bytes.
- R7: `line_ack` clears the length, the held flag and the overflow flag. A code presented in the same cycle as `line_ack` is dropped.
- R8: With 64 bytes stored, ordinary codes are dropped and `overflow` goes high. The flag stays high until 0x01, 0x0D or `line_ack`.
- R9: With `ch_valid` low, nothing in the block changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_valid | input | 1 | `ch_data` carries a code this cycle |
| ch_data | input | 8 | Incoming character code |
| line_ack | input | 1 | Release the held line and start an empty one |
| rd_addr | input | 6 | Byte index to read |
| rd_data | output | 8 | Stored byte at `rd_addr` |
| line_len | output | 7 | Number of bytes in the line (0 to 64) |
| line_done | output | 1 | One-cycle pulse after the line is closed |
| line_held | output | 1 | A closed line is waiting for acknowledge |
| overflow | output | 1 | An ordinary code was dropped because the store was full |

## Verification
The acknowledge and a valid character can land in the same cycle. The bench provokes this by driving `line_ack` with an ordinary code while a closed line is held. It judges the result by checking that the length returns to 0 rather than 1, and that the byte at index 0 is not the dropped code. A second collision happens when the store is full and an ordinary code arrives at the same time as a line end or a cancel. The bench fills all 64 bytes, pushes one more code, and then checks that 0x0D clears the overflow flag while it closes the line at length 64.

// File: rtl/line_editor_pkg.sv
// Package: shared code values and the character class type.
// Assumes 8-bit character codes.
package line_editor_pkg;

    localparam logic [7:0] CODE_BACK   = 8'h08;
    localparam logic [7:0] CODE_CANCEL = 8'h01;
    localparam logic [7:0] CODE_END    = 8'h0D;

    typedef enum logic [1:0] {
        CLS_PLAIN  = 2'd0,
        CLS_BACK   = 2'd1,
        CLS_CANCEL = 2'd2,
        CLS_END    = 2'd3
    } char_class_t;

endpackage

// File: rtl/line_char_decode.sv
// Module: sorts an incoming code into one of four classes.
// Assumes the code is only meaningful when the caller qualifies it with valid.
module line_char_decode
    import line_editor_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] code_in,
    output char_class_t       code_class
);

    // Compare the code against the three control values.
    always_comb begin
        if (code_in == DATA_W'(CODE_BACK))
            code_class = CLS_BACK;
        else if (code_in == DATA_W'(CODE_CANCEL))
            code_class = CLS_CANCEL;
        else if (code_in == DATA_W'(CODE_END))
            code_class = CLS_END;
        else
            code_class = CLS_PLAIN;
    end

endmodule

// File: rtl/line_store.sv
// Module: byte store with one write port and a same-cycle read port.
// Assumes the write address is always within range when the write enable is high.
module line_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write one byte on the clock edge.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Read without a clock.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/line_ctrl.sv
// Module: write position, held, done and overflow state for the line editor.
// Assumes line_ack takes priority over any code presented in the same cycle.
module line_ctrl
    import line_editor_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_valid,
    input  char_class_t       ch_class,
    input  logic              line_ack,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LEN_W-1:0]  len,
    output logic              done,
    output logic              held,
    output logic              ovf
);

    localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

    logic accept;
    logic is_full;

    assign accept  = ch_valid && !held && !line_ack;
    assign is_full = (len == FULL);

    // Drive the write strobe for an ordinary code while there is room.
    assign wr_en   = accept && (ch_class == CLS_PLAIN) && !is_full;
    assign wr_addr = len[ADDR_W-1:0];

    // Update the position and flags for each accepted code or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len  <= '0;
            done <= 1'b0;
            held <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (line_ack) begin
                len  <= '0;
                held <= 1'b0;
                ovf  <= 1'b0;
            end else if (accept) begin
                unique case (ch_class)
                    CLS_PLAIN: begin
                        if (is_full) ovf <= 1'b1;
                        else         len <= len + 1'b1;
                    end
                    CLS_BACK: begin
                        if (len != '0) len <= len - 1'b1;
                    end
                    CLS_CANCEL: begin
                        len <= '0;
                        ovf <= 1'b0;
                    end
                    CLS_END: begin
                        held <= 1'b1;
                        done <= 1'b1;
                        ovf  <= 1'b0;
                    end
                endcase
            end
        end
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_with_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> held);

    assert_held_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !line_ack) |=> $stable(len));

    assert_back_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ch_class == CLS_BACK && len == '0) |=> (len == '0));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_ack |=> (len == '0 && !held && !ovf));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (len == FULL));

    assert_idle_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_valid && !line_ack) |=> ($stable(len) && $stable(held) && $stable(ovf)));

    assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        len <= FULL);

endmodule

// File: rtl/line_editor.sv
// Module: top of the character line editing buffer.
// Assumes one code per cycle at most, qualified by ch_valid.
module line_editor
    import line_editor_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_valid,
    input  logic [DATA_W-1:0] ch_data,
    input  logic              line_ack,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [LEN_W-1:0]  line_len,
    output logic              line_done,
    output logic              line_held,
    output logic              overflow
);

    char_class_t       cls;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;

    line_char_decode #(.DATA_W(DATA_W)) u_decode (
        .code_in    (ch_data),
        .code_class (cls)
    );

    line_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_valid (ch_valid),
        .ch_class (cls),
        .line_ack (line_ack),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .len      (line_len),
        .done     (line_done),
        .held     (line_held),
        .ovf      (overflow)
    );

    line_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (ch_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/line_editor_test.sv
// Bench: a vector table walked by one loop, then directed corner tests.
module line_editor_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ch_valid;
    logic [7:0] ch_data;
    logic       line_ack;
    logic [5:0] rd_addr;
    logic [7:0] rd_data;
    logic [6:0] line_len;
    logic       line_done;
    logic       line_held;
    logic       overflow;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    line_editor uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_valid  (ch_valid),
        .ch_data   (ch_data),
        .line_ack  (line_ack),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .line_len  (line_len),
        .line_done (line_done),
        .line_held (line_held),
        .overflow  (overflow)
    );

    // Each entry holds valid, ack, data, and the expected len, done, held, ovf.
    localparam int NV = 13;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h41, 7'd1, 1'b0, 1'b0, 1'b0},  // R2 'A'
        {1'b1, 1'b0, 8'h42, 7'd2, 1'b0, 1'b0, 1'b0},  // R2 'B'
        {1'b1, 1'b0, 8'h08, 7'd1, 1'b0, 1'b0, 1'b0},  // R3 back
        {1'b1, 1'b0, 8'h43, 7'd2, 1'b0, 1'b0, 1'b0},  // R2 'C'
        {1'b0, 1'b0, 8'h5A, 7'd2, 1'b0, 1'b0, 1'b0},  // R9 idle
        {1'b1, 1'b0, 8'h01, 7'd0, 1'b0, 1'b0, 1'b0},  // R4 cancel
        {1'b1, 1'b0, 8'h08, 7'd0, 1'b0, 1'b0, 1'b0},  // R3 back at zero
        {1'b1, 1'b0, 8'h78, 7'd1, 1'b0, 1'b0, 1'b0},  // R2 'x'
        {1'b1, 1'b0, 8'h79, 7'd2, 1'b0, 1'b0, 1'b0},  // R2 'y'
        {1'b1, 1'b0, 8'h0D, 7'd2, 1'b1, 1'b1, 1'b0},  // R5 end
        {1'b1, 1'b0, 8'h71, 7'd2, 1'b0, 1'b1, 1'b0},  // R6 held
        {1'b1, 1'b1, 8'h72, 7'd0, 1'b0, 1'b0, 1'b0},  // R7 ack beats char
        {1'b1, 1'b0, 8'h6B, 7'd1, 1'b0, 1'b0, 1'b0}   // R2 'k'
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one input set for one clock, then sample 1 ns after the edge.
    task automatic step(input logic v, input logic a, input logic [7:0] d);
        @(negedge clk);
        ch_valid = v;
        line_ack = a;
        ch_data  = d;
        @(posedge clk);
        #1;
    endtask

    task automatic outs(input string req, input int len, input int dn,
                        input int hd, input int ov);
        chk({req, " len"},  int'(line_len),  len);
        chk({req, " done"}, int'(line_done), dn);
        chk({req, " held"}, int'(line_held), hd);
        chk({req, " ovf"},  int'(overflow),  ov);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ch_valid = 1'b0; line_ack = 1'b0; ch_data = 8'h00; rd_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        outs("R1 reset", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][19], VEC[i][18], VEC[i][17:10]);
            outs($sformatf("vector %0d", i), int'(VEC[i][9:3]),
                 int'(VEC[i][2]), int'(VEC[i][1]), int'(VEC[i][0]));
        end
        step(1'b0, 1'b0, 8'h00);

        // Read back: 'k' at 0 replaced the dropped 'r' (R7); 'y' at 1 (R2).
        rd_addr = 6'd0; #1;
        chk("R7 byte0 not dropped code", int'(rd_data), 8'h6B);
        rd_addr = 6'd1; #1;
        chk("R2 byte1", int'(rd_data), 8'h79);
        rd_addr = 6'd2; #1;
        chk("R5 end code not stored", int'(rd_data == 8'h0D), 0);
        chk("R6 held code not stored", int'(rd_data == 8'h71), 0);

        // Fill to 64 bytes and push past the end (R8).
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        for (int i = 0; i < 64; i++) step(1'b1, 1'b0, 8'(8'h20 + i));
        outs("R8 full", 64, 0, 0, 0);
        step(1'b1, 1'b0, 8'h7E);
        outs("R8 dropped", 64, 0, 0, 1);
        step(1'b0, 1'b0, 8'h00);
        rd_addr = 6'd63; #1;
        chk("R8 last byte kept", int'(rd_data), 8'h5F);
        step(1'b1, 1'b0, 8'h08);
        outs("R8 back keeps ovf", 63, 0, 0, 1);
        step(1'b1, 1'b0, 8'h01);
        outs("R4 cancel clears ovf", 0, 0, 0, 0);

        // Full again, overflow, then end the line (R5 with R8).
        for (int i = 0; i < 65; i++) step(1'b1, 1'b0, 8'h2A);
        outs("R8 refill", 64, 0, 0, 1);
        step(1'b1, 1'b0, 8'h0D);
        outs("R5 end clears ovf", 64, 1, 1, 0);
        step(1'b0, 1'b0, 8'h00);
        outs("R5 done single", 64, 0, 1, 0);

        // Reset in mid line (R1).
        step(1'b0, 1'b1, 8'h00);
        step(1'b1, 1'b0, 8'h33);
        @(negedge clk);
        ch_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        outs("R1 mid reset", 0, 0, 0, 0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule